// File: doc/BRIEF.md
# Product-code packet encoder

This block protects a packet of flits with a two-dimensional product code. The packet is treated as a bit array in which every flit is one column and each bit position across the flits is one row. Every data flit is encoded on its way through with a single-error-correcting, double-error-detecting column code. Its check bits go out appended to it, and the coded flit leaves on a valid/ready output stream. While the packet streams in, one even parity bit per row is accumulated by XOR, so the block never buffers the whole packet.

When the last flit of a packet is accepted, the row parity word is frozen in a holding register. This word is then encoded with the same column code, which yields the checks-on-checks. That encoded word forms a one-flit check packet. It is sent only when the receiver raises a retransmission request while the output register is empty. It can be resent on later requests until the first flit of the next packet is accepted, which discards it. The flit width is a parameter between 4 and 64 bits. The reset is asynchronous and active low, and its release must be synchronous to `clk`.

Top module: `pc_prod_encoder`

## Requirements
- R1: Each coded flit is laid out as {overall parity, C, data}. C is P column check bits, with P the smallest integer such that 2^P >= FLIT_W+P+1 (P=5 for a 16-bit flit). Data bit i takes the (i+1)-th codeword position, counted upward from 1, that is not a power of two. Check bit j is the XOR of the data bits whose position has bit j set.
- R2: The overall parity bit in the most significant position gives every coded flit an even number of ones.
- R3: Each accepted input flit appears exactly once on the output as a data flit, in arrival order. Its out_last equals the in_last it arrived with, and out_check is 0.
- R4: The held row parity word is the bitwise XOR of all data flits of the most recently completed packet.
- R5: A check flit carries the held row parity word, encoded by the R1 column code. It has out_check=1 and out_last=1, and it appears only in response to retx_req.
- R6: retx_req is accepted only when out_valid is 0 and a check word is held. A request at any other time produces no output.
- R7: A held check word can be resent on any number of requests until the first flit of the next packet is accepted. After that, a request is ignored until that packet completes.
- R8: When a request is accepted in the same cycle as an offered input flit, the request wins. in_ready is 0 in that cycle, and the flit is accepted later.
- R9: While out_valid=1 and out_ready=0, the output flit stays unchanged and in_ready is 0.
- R10: After reset, out_valid is 0, in_ready is 1, and no check word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit offered |
| in_ready | output | 1 | Input flit accepted this cycle when in_valid is high |
| in_data | input | FLIT_W | Uncoded flit |
| in_last | input | 1 | Offered flit closes its packet |
| out_valid | output | 1 | Output flit present |
| out_ready | input | 1 | Receiver takes the output flit |
| out_data | output | FLIT_W+P+1 | Coded flit |
| out_last | output | 1 | Output flit closes its packet |
| out_check | output | 1 | Output flit is the check packet |
| retx_req | input | 1 | Retransmission request for the held check packet |

## Verification
A retransmission request and a new input flit can compete for the output register in the same cycle. The bench provokes this by offering the first flit of a new packet together with a request while the output is empty and a check word is held. It judges the outcome on in_ready in that cycle, on the check flit that follows, and on the delayed data flit. A request that arrives during a stall, while a flit is draining, or after the next packet has started is also driven in the same cycle as flit traffic. Every cycle is compared against a behavioural reference model.

// File: rtl/pc_enc_pkg.sv
package pc_enc_pkg;

  typedef enum logic {
    KIND_DATA  = 1'b0,
    KIND_CHECK = 1'b1
  } flit_kind_e;

  // number of column check bits (without the overall parity bit)
  function automatic int chk_width(input int fw);
    int p;
    p = 1;
    while ((1 << p) < fw + p + 1) p++;
    return p;
  endfunction

  // 1-based codeword position of data bit idx (skips powers of two)
  function automatic int data_pos(input int idx);
    int pos;
    int cnt;
    pos = 0;
    cnt = -1;
    while (cnt < idx) begin
      pos++;
      if ((pos & (pos - 1)) != 0) cnt++;
    end
    return pos;
  endfunction

  // data bits covered by column check bit j
  function automatic logic [63:0] col_mask(input int fw, input int j);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < fw; i++) begin
      if (((data_pos(i) >> j) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pc_secded_enc.sv
module pc_secded_enc
  import pc_enc_pkg::*;
#(
  parameter int FLIT_W = 16,
  localparam int P      = chk_width(FLIT_W),
  localparam int CODE_W = FLIT_W + P + 1
) (
  input  logic [FLIT_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);

  logic [P-1:0] chk;

  for (genvar j = 0; j < P; j++) begin : g_chk
    localparam logic [63:0] MASK = col_mask(FLIT_W, j);
    assign chk[j] = ^(data_i & MASK[FLIT_W-1:0]);
  end

  assign code_o = {^{chk, data_i}, chk, data_i};

endmodule

// File: rtl/pc_row_acc.sv
module pc_row_acc #(
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [FLIT_W-1:0] data_i,
  output logic [FLIT_W-1:0] pcb_o,
  output logic              held_o
);

  logic [FLIT_W-1:0] acc_q, acc_d;
  logic [FLIT_W-1:0] pcb_q, pcb_d;
  logic              held_q, held_d;
  logic              mid_q, mid_d;
  logic [FLIT_W-1:0] row;

  assign row = acc_q ^ data_i;

  always_comb begin
    acc_d  = acc_q;
    pcb_d  = pcb_q;
    held_d = held_q;
    mid_d  = mid_q;
    if (!mid_q) held_d = 1'b0;
    if (last_i) begin
      pcb_d  = row;
      held_d = 1'b1;
      acc_d  = '0;
      mid_d  = 1'b0;
    end else begin
      acc_d  = row;
      mid_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pcb_q  <= '0;
      held_q <= 1'b0;
      mid_q  <= 1'b0;
    end else if (take_i) begin
      acc_q  <= acc_d;
      pcb_q  <= pcb_d;
      held_q <= held_d;
      mid_q  <= mid_d;
    end
  end

  assign pcb_o  = pcb_q;
  assign held_o = held_q;

  // R4: closing flit leaves a clean accumulator and a held word
  assert_acc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && last_i |=> (acc_q == '0) && held_q);

  // R7: opening flit of a longer packet discards the held word
  assert_hold_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !mid_q && !last_i |=> !held_q);

endmodule

// File: rtl/pc_out_reg.sv
module pc_out_reg
  import pc_enc_pkg::*;
#(
  parameter int CODE_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              last_i,
  input  flit_kind_e        kind_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] data_o,
  output logic              last_o,
  output flit_kind_e        kind_o
);

  logic              valid_q, valid_d;
  logic [CODE_W-1:0] data_q;
  logic              last_q;
  flit_kind_e        kind_q;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready_i) valid_d = 1'b0;
    if (load_i)             valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      last_q <= 1'b0;
      kind_q <= KIND_DATA;
    end else if (load_i) begin
      data_q <= data_i;
      last_q <= last_i;
      kind_q <= kind_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;
  assign kind_o  = kind_q;

  // R9: a stalled flit is held unchanged
  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready_i |=> valid_q && $stable(data_q) && $stable(last_q) && $stable(kind_q));

endmodule

// File: rtl/pc_prod_encoder.sv
module pc_prod_encoder
  import pc_enc_pkg::*;
#(
  parameter int FLIT_W = 16,
  localparam int P      = chk_width(FLIT_W),
  localparam int CODE_W = FLIT_W + P + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_check,
  input  logic              retx_req
);

  logic [CODE_W-1:0] dat_code;
  logic [CODE_W-1:0] coc_code;
  logic [FLIT_W-1:0] pcb;
  logic              held;
  logic              retx_take;
  logic              take;
  logic              load;
  logic [CODE_W-1:0] load_data;
  logic              load_last;
  flit_kind_e        load_kind;
  flit_kind_e        out_kind;

  // column code on the data path (stage one)
  pc_secded_enc #(.FLIT_W(FLIT_W)) u_col_enc (
    .data_i (in_data),
    .code_o (dat_code)
  );

  // row parity accumulation and hold (stage two)
  pc_row_acc #(.FLIT_W(FLIT_W)) u_row_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .last_i (in_last),
    .data_i (in_data),
    .pcb_o  (pcb),
    .held_o (held)
  );

  // column code over the row parity word: checks-on-checks (stage three)
  pc_secded_enc #(.FLIT_W(FLIT_W)) u_coc_enc (
    .data_i (pcb),
    .code_o (coc_code)
  );

  always_comb begin
    retx_take = retx_req && !out_valid && held;
    in_ready  = (!out_valid || out_ready) && !retx_take;
    take      = in_valid && in_ready;
    load      = take || retx_take;
    if (retx_take) begin
      load_data = coc_code;
      load_last = 1'b1;
      load_kind = KIND_CHECK;
    end else begin
      load_data = dat_code;
      load_last = in_last;
      load_kind = KIND_DATA;
    end
  end

  pc_out_reg #(.CODE_W(CODE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (load_data),
    .last_i  (load_last),
    .kind_i  (load_kind),
    .ready_i (out_ready),
    .valid_o (out_valid),
    .data_o  (out_data),
    .last_o  (out_last),
    .kind_o  (out_kind)
  );

  assign out_check = (out_kind == KIND_CHECK);

  // R2: every emitted flit has even overall weight
  assert_even_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^out_data) == 1'b0);

  // R5: the check packet is one flit long
  assert_check_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_check |-> out_last);

  // R6: a fresh check flit follows a request seen while the output was empty
  assert_check_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_check && !$past(out_valid && out_check)
      |-> $past(retx_req) && !$past(out_valid));

  // R9: no input is taken while the output is stalled
  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/pc_prod_encoder_test.sv
`timescale 1ns/1ps
module pc_prod_encoder_test;

  localparam int FW = 16;

  function automatic int tb_chk_bits(input int fw);
    int p;
    p = 0;
    while ((2 ** p) < fw + p + 1) p++;
    return p;
  endfunction

  localparam int P  = tb_chk_bits(FW);
  localparam int CW = FW + P + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [FW-1:0] in_data;
  logic          in_last;
  logic          out_valid;
  logic          out_ready;
  logic [CW-1:0] out_data;
  logic          out_last;
  logic          out_check;
  logic          retx_req;

  always #2 clk = ~clk;

  pc_prod_encoder #(.FLIT_W(FW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_check (out_check),
    .retx_req  (retx_req)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // behavioural column code: build the codeword by position, then fill parity slots
  function automatic logic [CW-1:0] enc(input logic [FW-1:0] d);
    bit arr [0:127];
    logic [P-1:0] c;
    int idx;
    bit par;
    for (int k = 0; k < 128; k++) arr[k] = 1'b0;
    idx = 0;
    for (int pos = 1; pos <= FW + P; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        arr[pos] = d[idx];
        idx++;
      end
    end
    for (int j = 0; j < P; j++) begin
      par = 1'b0;
      for (int pos = 1; pos <= FW + P; pos++)
        if (((pos >> j) & 1) == 1 && pos != (1 << j)) par = par ^ arr[pos];
      c[j] = par;
    end
    return {(^d) ^ (^c), c, d};
  endfunction

  // reference model state
  bit            m_ov;
  logic [CW-1:0] m_data;
  bit            m_last;
  bit            m_chk;
  bit            m_hold;
  logic [FW-1:0] m_pcb;
  logic [FW-1:0] m_cur [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ov = 0; m_data = '0; m_last = 0; m_chk = 0; m_hold = 0; m_pcb = '0;
      m_cur.delete();
    end else begin
      bit take_r;
      bit rdy;
      take_r = retx_req && !m_ov && m_hold;
      rdy    = (!m_ov || out_ready) && !take_r;
      if (m_ov && out_ready) m_ov = 0;
      if (take_r) begin
        m_ov = 1; m_data = enc(m_pcb); m_last = 1; m_chk = 1;
      end else if (in_valid && rdy) begin
        m_ov = 1; m_data = enc(in_data); m_last = in_last; m_chk = 0;
        if (m_cur.size() == 0) m_hold = 0;
        m_cur.push_back(in_data);
        if (in_last) begin
          m_pcb = '0;
          foreach (m_cur[k]) m_pcb = m_pcb ^ m_cur[k];
          m_hold = 1;
          m_cur.delete();
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit exp_rdy;
    if (!rst_n) return;
    chk("R6 out_valid", 64'(out_valid), 64'(m_ov));
    if (m_ov) begin
      if (m_chk) chk("R5 check flit data", 64'(out_data), 64'(m_data));
      else       chk("R1 data flit code", 64'(out_data), 64'(m_data));
      chk("R3 out_last", 64'(out_last), 64'(m_last));
      chk("R5 out_check", 64'(out_check), 64'(m_chk));
      chk("R2 even weight", 64'(^out_data), 64'd0);
    end
    exp_rdy = (!m_ov || out_ready) && !(retx_req && !m_ov && m_hold);
    if (m_ov && !out_ready) chk("R9 in_ready", 64'(in_ready), 64'(exp_rdy));
    else                    chk("R8 in_ready", 64'(in_ready), 64'(exp_rdy));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  logic [7:0]    lf = 8'h5B;
  logic [FW-1:0] pkt [$];

  task automatic send_flits(input bit close, input bit rnd);
    for (int k = 0; k < pkt.size(); k++) begin
      bit done;
      done = 0;
      while (!done) begin
        in_valid = 1'b1;
        in_data  = pkt[k];
        in_last  = close && (k == pkt.size() - 1);
        if (rnd) begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          out_ready = lf[0] | lf[2];
        end
        #1;
        done = in_ready;
        tick();
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    retx_req = 1'b0;
    repeat (n) tick();
  endtask

  task automatic retx_pulse();
    retx_req = 1'b1;
    tick();
    retx_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_data = '0; in_last = 0; out_ready = 1; retx_req = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R10 in_ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R10/R6: nothing held after reset, request ignored
    retx_pulse();
    tick();
    chk("R10 no check after reset", 64'(out_valid), 64'd0);

    // R1 R3 R4: three-flit packet, then request
    pkt = '{16'h1234, 16'hFF00, 16'h0F0F};
    send_flits(1, 0);
    idle(3);
    retx_pulse();
    chk("R5 check flit present", 64'(out_valid && out_check), 64'd1);
    chk("R4 row parity word", 64'(out_data[FW-1:0]), 64'h0000_0000_0000_E23B);
    idle(2);
    retx_pulse();
    chk("R7 repeat before next packet", 64'(out_valid && out_check), 64'd1);
    idle(2);

    // R6: request while a flit is stalled is ignored
    out_ready = 1'b0;
    pkt = '{16'hABCD};
    send_flits(1, 0);
    retx_pulse();
    out_ready = 1'b1;
    tick();
    chk("R6 request during busy ignored", 64'(out_valid), 64'd0);

    // R9: random back-pressure over a longer packet
    pkt = '{16'h0001, 16'h8000, 16'h7E7E, 16'hC3C3, 16'h1F2E};
    send_flits(1, 1);
    out_ready = 1'b1;
    idle(3);

    // R8: request and new first flit in the same cycle
    in_valid = 1'b1; in_data = 16'h1111; in_last = 1'b0; retx_req = 1'b1;
    #1;
    chk("R8 input blocked by request", 64'(in_ready), 64'd0);
    tick();
    retx_req = 1'b0;
    chk("R8 check flit wins", 64'(out_valid && out_check), 64'd1);
    pkt = '{16'h1111, 16'h2222};
    send_flits(0, 0);
    idle(2);

    // R7: request after the next packet started is ignored
    retx_pulse();
    tick();
    chk("R7 request mid packet ignored", 64'(out_valid), 64'd0);
    pkt = '{16'h4444};
    send_flits(1, 0);
    idle(2);
    retx_pulse();
    chk("R4 parity of split packet", 64'(out_data[FW-1:0]), 64'h0000_0000_0000_7777);
    idle(2);

    // R3: single-flit packet
    pkt = '{16'h5A5A};
    send_flits(1, 0);
    chk("R3 single flit last", 64'(out_last), 64'd1);
    idle(2);
    retx_pulse();
    chk("R4 single flit parity", 64'(out_data[FW-1:0]), 64'h0000_0000_0000_5A5A);
    idle(3);

    finish_run();
  end

endmodule